// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits between the host write path of a byte-wide flash device and its page-write and erase machinery. It watches every host write. A write is either one step of a multi-write unlock command or a byte bound for the page buffer. The commands are three, six or seven writes long and share a common two-write key. Together they switch write protection on or off, start a full-array erase, enter and leave an identification mode, and permanently lock the lowest or highest 16 KB region of the array against writes.

Protection and the two region locks live in registers that only the initialising reset `rst_n` clears or sets. Protection comes up enabled after that reset. The `pwr_cycle` input models a supply drop. It returns the command tracker to idle, leaves identification mode and closes any open load window, but it leaves protection and the locks untouched. While identification mode is on, four fixed read addresses return identity and lock-status codes in place of array data.

The write input is a stream with no back-pressure. Every cycle with `wr_valid` high is one complete host write and is consumed in that cycle. There is no ready signal, so the source never stalls. A write passed to the page buffer shows up as a single-cycle `byte_load` pulse in the cycle after it was presented. A write that is not passed produces no pulse.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After `rst_n`, protection is on, `id_mode`, `lock_lo`, `lock_hi` and `erase_req` are 0, and a plain write produces no `byte_load`.
- R2: The writes (5555,AA), (2AAA,55), (5555,A0) turn protection on and open a load window. While protection is on and the window is open, every write is passed as a page byte. While protection is on and the window is closed, plain writes are dropped.
- R3: The six writes (5555,AA), (2AAA,55), (5555,80), (5555,AA), (2AAA,55), (5555,20) turn protection off. From then on, plain writes are passed as page bytes.
- R4: Command writes are never passed. A write that does not match the next expected step returns the tracker to idle. With protection off, that write is passed as a page byte.
- R5: The six-write form ending in (5555,10) raises `erase_req` for exactly one cycle. When either region lock is set, the request is not raised.
- R6: The six-write form ending in (5555,60) and the three-write form ending in (5555,90) set `id_mode`. The three-write form ending in (5555,F0) clears it, and so does a `pwr_cycle` pulse.
- R7: With `id_mode` set, reads return DA at address 00000, 46 at 00001, FF or FE at 00002 (low region locked or not) and FF or FE at 7FFF2 (high region). All other reads, and all reads outside identification mode, return `array_rd_data`.
- R8: The six-write form ending in (5555,40), followed by (00000,00), sets `lock_lo`. Followed by (7FFFF,FF), it sets `lock_hi`. Both locks and the protection state survive `pwr_cycle`.
- R9: A page byte whose address has bits 18:14 all zero while `lock_lo` is set is dropped. A page byte with bits 18:14 all ones while `lock_hi` is set is also dropped. Other addresses still load.
- R10: Command steps compare only address bits 14:0, so 45555 and 32AAA act as 5555 and 2AAA.
- R11: A `page_end` pulse closes the load window, so a later plain write under protection is dropped.
- R12: A passed write appears on `byte_load`, `byte_addr` and `byte_data` in the cycle after `wr_valid`, for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low initialising reset; sets protection, clears locks |
| pwr_cycle | input | 1 | Supply-drop pulse; clears tracker, window and identification mode |
| page_end | input | 1 | Page-write controller reports end of the current page load |
| wr_valid | input | 1 | One host write this cycle (no back-pressure) |
| wr_addr | input | 19 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 19 | Host read address |
| array_rd_data | input | 8 | Data read from the array at `rd_addr` |
| byte_load | output | 1 | Pulse: pass one byte to the page buffer |
| byte_addr | output | 19 | Address of the passed byte |
| byte_data | output | 8 | Value of the passed byte |
| erase_req | output | 1 | Pulse: start a full-array erase |
| id_mode | output | 1 | Identification mode active |
| lock_lo | output | 1 | Lowest 16 KB region locked |
| lock_hi | output | 1 | Highest 16 KB region locked |
| rd_data | output | 8 | Read data after identification override |

## Verification
The main sweep tries every one of the 256 data values as the third write after the two-write key, with protection off. This separates the four codes that act at step three (A0, 90, F0, 80) from the 252 that must abort and fall through as page bytes. The bench also runs each six- and seven-write command, and it injects a wrong write in the middle of a command to show that only the offending write escapes. Keys with high address bits set show which address bits are compared. Each `pwr_cycle` check is placed so that it tells state that survives a power drop (protection, locks) apart from state that does not (identification mode, load window).

// File: rtl/udec_pkg.sv
package udec_pkg;
  localparam int CMP_W = 15;
  localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] KEY_DATA_A = 8'hAA;
  localparam logic [7:0] KEY_DATA_B = 8'h55;
  localparam logic [7:0] OP_PROT_ON  = 8'hA0;
  localparam logic [7:0] OP_ID_SHORT = 8'h90;
  localparam logic [7:0] OP_ID_EXIT  = 8'hF0;
  localparam logic [7:0] OP_LONG     = 8'h80;
  localparam logic [7:0] OP_PROT_OFF = 8'h20;
  localparam logic [7:0] OP_ERASE    = 8'h10;
  localparam logic [7:0] OP_ID_LONG  = 8'h60;
  localparam logic [7:0] OP_LOCK     = 8'h40;
  localparam logic [7:0] ID_MFR      = 8'hDA;
  localparam logic [7:0] ID_DEV      = 8'h46;
  localparam logic [7:0] ID_LOCKED   = 8'hFF;
  localparam logic [7:0] ID_OPEN     = 8'hFE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_EXT3, ST_EXT4, ST_EXT5, ST_LOCK6
  } seq_t;
endpackage

// File: rtl/udec_match.sv
module udec_match
  import udec_pkg::*;
(
  input  logic [CMP_W-1:0] addr,
  input  logic [7:0]       data,
  output logic             at_a,
  output logic             key_a,
  output logic             key_b,
  output logic             lock_lo_step,
  output logic             lock_hi_step
);
  always_comb begin
    at_a         = (addr == KEY_ADDR_A);
    key_a        = at_a && (data == KEY_DATA_A);
    key_b        = (addr == KEY_ADDR_B) && (data == KEY_DATA_B);
    lock_lo_step = (addr == '0) && (data == 8'h00);
    lock_hi_step = (&addr) && (data == 8'hFF);
  end
endmodule

// File: rtl/udec_region.sv
module udec_region #(
  parameter int HI_W = 5
) (
  input  logic [HI_W-1:0] addr_hi,
  input  logic            lock_lo,
  input  logic            lock_hi,
  output logic            blocked
);
  always_comb begin
    blocked = (lock_lo && (addr_hi == '0)) || (lock_hi && (&addr_hi));
  end
endmodule

// File: rtl/udec_idmux.sv
module udec_idmux
  import udec_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_rd_data,
  input  logic              id_mode,
  input  logic              lock_lo,
  input  logic              lock_hi,
  output logic [7:0]        rd_data
);
  localparam logic [ADDR_W-1:0] A_MFR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DEV = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HI  = {{(ADDR_W-4){1'b1}}, 4'h2};

  always_comb begin
    rd_data = array_rd_data;
    if (id_mode) begin
      if (rd_addr == A_MFR)      rd_data = ID_MFR;
      else if (rd_addr == A_DEV) rd_data = ID_DEV;
      else if (rd_addr == A_LO)  rd_data = lock_lo ? ID_LOCKED : ID_OPEN;
      else if (rd_addr == A_HI)  rd_data = lock_hi ? ID_LOCKED : ID_OPEN;
    end
  end
endmodule

// File: rtl/udec_fsm.sv
module udec_fsm
  import udec_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BOOT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_cycle,
  input  logic              page_end,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              at_a,
  input  logic              key_a,
  input  logic              key_b,
  input  logic              lock_lo_step,
  input  logic              lock_hi_step,
  input  logic              blocked,
  output logic              byte_load,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        byte_data,
  output logic              erase_req,
  output logic              id_mode,
  output logic              lock_lo,
  output logic              lock_hi
);
  seq_t st_q, st_d;
  logic prot_q, win_q;
  logic wr_ok, consumed, pass;
  logic set_prot, clr_prot, set_id, clr_id, do_erase, set_llo, set_lhi;

  assign wr_ok = wr_valid && !pwr_cycle;

  always_comb begin
    st_d = st_q;
    consumed = 1'b0;
    set_prot = 1'b0; clr_prot = 1'b0;
    set_id = 1'b0;   clr_id = 1'b0;
    do_erase = 1'b0;
    set_llo = 1'b0;  set_lhi = 1'b0;
    if (wr_ok) begin
      st_d = ST_IDLE;
      if (!(prot_q && win_q)) begin
        unique case (st_q)
          ST_IDLE: if (key_a) begin st_d = ST_KEY1; consumed = 1'b1; end
          ST_KEY1: if (key_b) begin st_d = ST_KEY2; consumed = 1'b1; end
          ST_KEY2: if (at_a) begin
            consumed = 1'b1;
            case (wr_data)
              OP_PROT_ON:  set_prot = 1'b1;
              OP_ID_SHORT: set_id = 1'b1;
              OP_ID_EXIT:  clr_id = 1'b1;
              OP_LONG:     st_d = ST_EXT3;
              default:     consumed = 1'b0;
            endcase
          end
          ST_EXT3: if (key_a) begin st_d = ST_EXT4; consumed = 1'b1; end
          ST_EXT4: if (key_b) begin st_d = ST_EXT5; consumed = 1'b1; end
          ST_EXT5: if (at_a) begin
            consumed = 1'b1;
            case (wr_data)
              OP_PROT_OFF: clr_prot = 1'b1;
              OP_ERASE:    do_erase = !lock_lo && !lock_hi;
              OP_ID_LONG:  set_id = 1'b1;
              OP_LOCK:     st_d = ST_LOCK6;
              default:     consumed = 1'b0;
            endcase
          end
          ST_LOCK6: begin
            consumed = lock_lo_step || lock_hi_step;
            set_llo  = lock_lo_step;
            set_lhi  = lock_hi_step;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
    pass = wr_ok && !consumed && (!prot_q || win_q) && !blocked;
  end

  // state that survives a supply drop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q  <= 1'b1;
      lock_lo <= 1'b0;
      lock_hi <= 1'b0;
    end else begin
      if (set_prot)      prot_q <= 1'b1;
      else if (clr_prot) prot_q <= 1'b0;
      if (set_llo) lock_lo <= 1'b1;
      if (set_lhi) lock_hi <= 1'b1;
    end
  end

  // state lost on a supply drop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      win_q     <= 1'b0;
      id_mode   <= 1'b0;
      erase_req <= 1'b0;
      byte_load <= 1'b0;
      byte_addr <= '0;
      byte_data <= '0;
    end else if (pwr_cycle) begin
      st_q      <= ST_IDLE;
      win_q     <= 1'b0;
      id_mode   <= 1'b0;
      erase_req <= 1'b0;
      byte_load <= 1'b0;
    end else begin
      st_q      <= st_d;
      erase_req <= do_erase;
      byte_load <= pass;
      if (pass) begin
        byte_addr <= wr_addr;
        byte_data <= wr_data;
      end
      if (set_prot)                  win_q <= 1'b1;
      else if (clr_prot || page_end) win_q <= 1'b0;
      if (set_id)      id_mode <= 1'b1;
      else if (clr_id) id_mode <= 1'b0;
    end
  end

  p_erase_needs_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (!lock_lo && !lock_hi));
  p_erase_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
  p_id_cleared_by_pwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle |=> !id_mode);
  p_lock_lo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lo |=> lock_lo);
  p_lock_hi_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hi |=> lock_hi);
  p_no_load_locked_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_load && lock_lo) |-> (byte_addr[ADDR_W-1:BOOT_W] != '0));
  p_no_load_locked_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_load && lock_hi) |-> !(&byte_addr[ADDR_W-1:BOOT_W]));
endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import udec_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BOOT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_cycle,
  input  logic              page_end,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_rd_data,
  output logic              byte_load,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        byte_data,
  output logic              erase_req,
  output logic              id_mode,
  output logic              lock_lo,
  output logic              lock_hi,
  output logic [7:0]        rd_data
);
  localparam int HI_W = ADDR_W - BOOT_W;

  logic at_a, key_a, key_b, lo_step, hi_step, blocked;

  udec_match u_match (
    .addr(wr_addr[CMP_W-1:0]), .data(wr_data),
    .at_a(at_a), .key_a(key_a), .key_b(key_b),
    .lock_lo_step(lo_step), .lock_hi_step(hi_step)
  );

  udec_region #(.HI_W(HI_W)) u_region (
    .addr_hi(wr_addr[ADDR_W-1:BOOT_W]), .lock_lo(lock_lo),
    .lock_hi(lock_hi), .blocked(blocked)
  );

  udec_fsm #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .page_end(page_end),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .at_a(at_a), .key_a(key_a), .key_b(key_b),
    .lock_lo_step(lo_step), .lock_hi_step(hi_step), .blocked(blocked),
    .byte_load(byte_load), .byte_addr(byte_addr), .byte_data(byte_data),
    .erase_req(erase_req), .id_mode(id_mode),
    .lock_lo(lock_lo), .lock_hi(lock_hi)
  );

  udec_idmux #(.ADDR_W(ADDR_W)) u_idmux (
    .rd_addr(rd_addr), .array_rd_data(array_rd_data), .id_mode(id_mode),
    .lock_lo(lock_lo), .lock_hi(lock_hi), .rd_data(rd_data)
  );
endmodule

// File: tb/sim_unlock_cmd_decoder.sv
`timescale 1ns/1ps
module sim_unlock_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_cycle = 1'b0, page_end = 1'b0, wr_valid = 1'b0;
  logic [18:0] wr_addr = '0, rd_addr = '0, byte_addr;
  logic [7:0] wr_data = '0, array_rd_data, byte_data, rd_data;
  logic byte_load, erase_req, id_mode, lock_lo, lock_hi;
  int checks = 0, errors = 0;
  logic g_load, g_erase;
  logic [18:0] g_addr;
  logic [7:0] g_data;

  always #10 clk = ~clk;
  assign array_rd_data = rd_addr[7:0] ^ 8'h3C;

  unlock_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .page_end(page_end),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .array_rd_data(array_rd_data),
    .byte_load(byte_load), .byte_addr(byte_addr), .byte_data(byte_data),
    .erase_req(erase_req), .id_mode(id_mode), .lock_lo(lock_lo),
    .lock_hi(lock_hi), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
    g_load = byte_load; g_addr = byte_addr; g_data = byte_data; g_erase = erase_req;
  endtask

  task automatic exp_load(input string tag, input logic [18:0] a, input logic [7:0] d);
    chk(g_load && g_addr == a && g_data == d, tag,
        {4'h0, g_load, g_addr, g_data}, {4'h0, 1'b1, a, d});
  endtask

  task automatic exp_none(input string tag);
    chk(!g_load, tag, {31'h0, g_load}, 32'h0);
  endtask

  task automatic seq3(input logic [7:0] d);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, d);
  endtask

  task automatic seq6(input logic [7:0] d);
    seq3(8'h80); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, d);
  endtask

  task automatic pulse_pwr();
    @(negedge clk); pwr_cycle = 1'b1; @(negedge clk); pwr_cycle = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); page_end = 1'b1; @(negedge clk); page_end = 1'b0;
  endtask

  task automatic rd(input logic [18:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); rd_addr = a; #1;
    chk(rd_data == e, tag, {24'h0, rd_data}, {24'h0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!id_mode && !lock_lo && !lock_hi && !erase_req, "R1 reset flags",
        {28'h0, id_mode, lock_lo, lock_hi, erase_req}, 32'h0);
    wr(19'h01234, 8'h77); exp_none("R1 plain write dropped under protection");

    // R2 protected page load
    seq3(8'hA0); exp_none("R2 command byte not loaded");
    wr(19'h11234, 8'h5A); exp_load("R2 window passes byte", 19'h11234, 8'h5A);
    @(negedge clk); chk(!byte_load, "R12 load lasts one cycle", {31'h0, byte_load}, 32'h0);
    wr(19'h05555, 8'hAA); exp_load("R2 window does not decode keys", 19'h05555, 8'hAA);
    pulse_end();
    wr(19'h11235, 8'h5B); exp_none("R11 closed window drops byte");

    // R3 disable protection
    seq6(8'h20); exp_none("R3 command byte not loaded");
    wr(19'h22222, 8'hC3); exp_load("R3 plain write passes", 19'h22222, 8'hC3);

    // R10 high address bits ignored
    wr(19'h45555, 8'hAA); wr(19'h32AAA, 8'h55); wr(19'h65555, 8'h90);
    chk(id_mode, "R10 keys with high bits", {31'h0, id_mode}, 32'h1);
    seq3(8'hF0); chk(!id_mode, "R6 short exit", {31'h0, id_mode}, 32'h0);

    // sweep every third-step data value, protection off
    for (int d = 0; d < 256; d++) begin
      wr(19'h05555, 8'hAA); exp_none("R4 key1 consumed");
      wr(19'h02AAA, 8'h55); exp_none("R4 key2 consumed");
      wr(19'h05555, 8'(d));
      case (8'(d))
        8'hA0: begin
          exp_none("R2 enable consumed");
          wr(19'h00400, 8'h01); exp_load("R2 window open", 19'h00400, 8'h01);
          pulse_end();
          seq6(8'h20);
        end
        8'h90: begin
          exp_none("R6 entry consumed");
          chk(id_mode, "R6 short entry", {31'h0, id_mode}, 32'h1);
          seq3(8'hF0);
          chk(!id_mode, "R6 exit", {31'h0, id_mode}, 32'h0);
        end
        8'hF0: begin
          exp_none("R6 exit consumed");
          chk(!id_mode, "R6 exit idle", {31'h0, id_mode}, 32'h0);
        end
        8'h80: begin
          exp_none("R4 long prefix consumed");
          wr(19'h00100, 8'h33); exp_load("R4 abort at step 4", 19'h00100, 8'h33);
        end
        default: exp_load("R4 abort at step 3 passes", 19'h05555, 8'(d));
      endcase
    end

    // R4 abort mid long sequence
    seq3(8'h80); wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h56); exp_load("R4 bad step 5 passes", 19'h02AAA, 8'h56);
    wr(19'h05555, 8'h60); exp_load("R4 tracker back to idle", 19'h05555, 8'h60);
    chk(!id_mode, "R4 no entry after abort", {31'h0, id_mode}, 32'h0);

    // R6/R7 identification
    seq6(8'h60); chk(id_mode, "R6 long entry", {31'h0, id_mode}, 32'h1);
    rd(19'h00000, 8'hDA, "R7 maker code");
    rd(19'h00001, 8'h46, "R7 device code");
    rd(19'h00002, 8'hFE, "R7 low region open");
    rd(19'h7FFF2, 8'hFE, "R7 high region open");
    rd(19'h00005, 8'h05 ^ 8'h3C, "R7 other address array");
    pulse_pwr();
    chk(!id_mode, "R6 power drop exits", {31'h0, id_mode}, 32'h0);
    rd(19'h00000, 8'h00 ^ 8'h3C, "R7 array outside id mode");

    // R5 erase
    seq6(8'h10);
    chk(g_erase && !g_load, "R5 erase pulse", {30'h0, g_erase, g_load}, 32'h2);
    @(negedge clk); chk(!erase_req, "R5 erase one cycle", {31'h0, erase_req}, 32'h0);

    // R8 lock low region
    seq6(8'h40); wr(19'h00000, 8'h00);
    exp_none("R8 lock step consumed");
    chk(lock_lo && !lock_hi, "R8 low lock set", {30'h0, lock_lo, lock_hi}, 32'h2);
    wr(19'h01000, 8'h44); exp_none("R9 low region blocked");
    wr(19'h10000, 8'h45); exp_load("R9 rest programmable", 19'h10000, 8'h45);
    seq6(8'h10); chk(!g_erase, "R5 erase ignored when locked", {31'h0, g_erase}, 32'h0);
    @(negedge clk); chk(!erase_req, "R5 erase stays low", {31'h0, erase_req}, 32'h0);

    // R8 persistence over power drop
    pulse_pwr();
    chk(lock_lo, "R8 lock survives power drop", {31'h0, lock_lo}, 32'h1);
    wr(19'h20000, 8'h46); exp_load("R8 unprotected survives", 19'h20000, 8'h46);
    seq3(8'hA0); pulse_end(); pulse_pwr();
    wr(19'h20001, 8'h47); exp_none("R8 protection survives");

    // R8 lock high region, under protection
    seq6(8'h40); wr(19'h7FFFF, 8'hFF);
    chk(lock_hi, "R8 high lock set", {31'h0, lock_hi}, 32'h1);
    seq3(8'h90);
    rd(19'h7FFF2, 8'hFF, "R7 high region locked");
    rd(19'h00002, 8'hFF, "R7 low region locked");
    seq3(8'hF0);
    seq3(8'hA0);
    wr(19'h7C000, 8'h11); exp_none("R9 high region blocked");
    wr(19'h40000, 8'h22); exp_load("R9 middle loads", 19'h40000, 8'h22);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule